// File: doc/BRIEF.md
# Modem Line Change Interrupt Unit

This unit watches the three incoming modem handshake lines of a serial port: carrier detect (DCD), data set ready (DSR) and clear to send (CTS). Each line is brought into the core clock domain through a two-flop synchroniser. The synchronised levels can be read at any time. When any synchronised level differs from its value one cycle earlier, a pending modem interrupt is latched. The latch holds until software clears it.

Software services the interrupt as follows. It reads the live levels and compares them with a copy it keeps of the last levels it saw. It then acknowledges by writing a one to a dedicated acknowledge bit of the raw interrupt register. The unit keeps no per-line change flags. If a line toggles twice before service, the levels look unchanged, but the interrupt is still pending. An enable bit gates the pending bit onto the interrupt output and into the masked status register. The enable register also holds three other enable bits that belong to neighbouring interrupt sources. Those bits are stored and read back, and each can be changed without touching the modem enable.

Top module: `mdm_chg_irq`

## Requirements
- R1: While reset (synchronous, active high) is asserted and on the cycle after it, the level register, raw register, enable register and masked register all read 0, and `modem_irq` is 0.
- R2: The level register at offset 0x10 reads CTS in bit 0, DSR in bit 1 and DCD in bit 2, with all other bits 0. A change on an input line appears there after the second rising clock edge that samples the new value.
- R3: A change on any one of the three lines sets the modem pending bit one cycle after the change shows in the level register. The pending bit reads as bit 2 of the raw register at offset 0x14, and all other bits of that register read 0.
- R4: The pending bit stays set until it is acknowledged. Two opposite transitions on one line before service leave the level register unchanged, and the pending bit stays 1.
- R5: A write to offset 0x14 with data bit 4 equal to 1 clears the pending bit at that clock edge. A write to 0x14 with bit 4 equal to 0 leaves it unchanged.
- R6: If a new line change reaches the detector in the same cycle as an acknowledge write, the pending bit stays 1.
- R7: The enable register at offset 0x18 stores write data bits 3:0 and reads them back in bits 3:0. Bit 2 is the modem enable. The masked register at offset 0x1c reads bit 2 as pending AND modem enable, with all other bits 0. `modem_irq` equals that masked bit.
- R8: Line levels held constant through reset, including non-zero levels, produce no pending interrupt after reset is released.
- R9: Writes to offsets 0x10 and 0x1c, and to any unmapped offset, change no register. Reads from an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 5 | Byte offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| modem_irq | output | 1 | Masked modem interrupt |

## Verification
Two events can fall on the same clock edge: the detector seeing a fresh line change, and an acknowledge write. The bench provokes this by toggling a line and then, exactly two falling edges later, presenting the acknowledge write, so that the write lands on the edge where the detector asserts its change. After that edge the pending bit must read 1. This separates set-over-clear priority from clear-over-set priority, which would leave the bit at 0. A behavioural per-cycle model also judges the read data and the interrupt output on every clock, across double toggles, enable flips and writes to read-only offsets.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int LINE_N  = 3;
    localparam int SYNC_N  = 2;
    localparam int AW      = 5;
    localparam int DW      = 8;
    localparam int EN_W    = 4;
    localparam int BIT_MDM = 2;
    localparam int BIT_ACK = 4;

    localparam logic [AW-1:0] OFF_LVL = 5'h10;
    localparam logic [AW-1:0] OFF_RAW = 5'h14;
    localparam logic [AW-1:0] OFF_EN  = 5'h18;
    localparam logic [AW-1:0] OFF_MSK = 5'h1C;

    // bit 0 cts, bit 1 dsr, bit 2 dcd
    typedef struct packed {
        logic dcd;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    typedef enum logic [2:0] {
        SEL_LVL,
        SEL_RAW,
        SEL_EN,
        SEL_MSK,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e addr_to_sel(input logic [AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_LVL: s = SEL_LVL;
            OFF_RAW: s = SEL_RAW;
            OFF_EN:  s = SEL_EN;
            OFF_MSK: s = SEL_MSK;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_delta_latch.sv
module mdm_delta_latch #(
    parameter int W      = 3,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         ack,
    output logic         pend
);
    localparam int CW = $clog2(SYNC_N + 2);
    localparam logic [CW-1:0] ARM_AT = CW'(SYNC_N + 1);

    logic [W-1:0]  prev_q;
    logic [CW-1:0] fill_q;
    logic          pend_q;
    logic          armed;
    logic          chg;

    assign armed = (fill_q == ARM_AT);
    assign chg   = armed && (lvl != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            fill_q <= '0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (!armed) begin
                fill_q <= fill_q + 1'b1;
            end
            if (chg) begin
                pend_q <= 1'b1;
            end else if (ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend = pend_q;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        chg |=> pend);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !chg) |=> !pend);

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);

    // R8
    quiet_fill_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !pend);
endmodule

// File: rtl/mdm_regfile.sv
module mdm_regfile
    import mdm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  mdm_lines_t    lvl,
    input  logic          pend,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    reg_sel_e        sel;
    logic [EN_W-1:0] en_q;
    logic            masked;

    assign sel    = addr_to_sel(addr);
    assign ack    = wr && (sel == SEL_RAW) && wdata[BIT_ACK];
    assign masked = pend & en_q[BIT_MDM];
    assign irq    = masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr && sel == SEL_EN) begin
            en_q <= wdata[EN_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_LVL: rdata[LINE_N-1:0] = lvl;
            SEL_RAW: rdata[BIT_MDM]    = pend;
            SEL_EN:  rdata[EN_W-1:0]   = en_q;
            SEL_MSK: rdata[BIT_MDM]    = masked;
            default: rdata = '0;
        endcase
    end

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == SEL_EN) |=> $stable(en_q));
endmodule

// File: rtl/mdm_chg_irq.sv
module mdm_chg_irq
    import mdm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cts_in,
    input  logic          dsr_in,
    input  logic          dcd_in,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          modem_irq
);
    logic [LINE_N-1:0] raw_lines;
    logic [LINE_N-1:0] sync_lines;
    mdm_lines_t        lvl;
    logic              pend;
    logic              ack;

    assign raw_lines = {dcd_in, dsr_in, cts_in};

    for (genvar g = 0; g < LINE_N; g++) begin : g_sync
        mdm_sync #(.STAGES(SYNC_N)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    assign lvl = mdm_lines_t'(sync_lines);

    mdm_delta_latch #(.W(LINE_N), .SYNC_N(SYNC_N)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lines),
        .ack  (ack),
        .pend (pend)
    );

    mdm_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .lvl   (lvl),
        .pend  (pend),
        .ack   (ack),
        .rdata (reg_rdata),
        .irq   (modem_irq)
    );
endmodule

// File: tb/sim_mdm_chg_irq.sv
module sim_mdm_chg_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] lines = 3'b000;   // {dcd, dsr, cts}
    logic       wr = 1'b0;
    logic [4:0] addr = 5'h10;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mdm_chg_irq u0 (
        .clk(clk), .rst(rst),
        .cts_in(lines[0]), .dsr_in(lines[1]), .dcd_in(lines[2]),
        .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .modem_irq(irq)
    );

    // behavioural reference: sample history queue plus pending/enable state
    logic [2:0] hist[$];
    logic [2:0] m_lvl, m_last;
    int         m_age;
    bit         m_pend;
    logic [3:0] m_en;

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        case (a)
            5'h10: return {5'b0, m_lvl};
            5'h14: return {5'b0, m_pend, 2'b0};
            5'h18: return {4'b0, m_en};
            5'h1C: return {5'b0, m_pend & m_en[2], 2'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h10: return "R2";
            5'h14: return "R3";
            5'h18: return "R7";
            5'h1C: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        m_lvl = 0; m_last = 0; m_age = 0; m_pend = 0; m_en = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_lvl = 0; m_last = 0; m_age = 0; m_pend = 0; m_en = 0;
        end else begin
            bit fresh;
            bit clr;
            fresh = (m_age > 2) && (m_lvl != m_last);
            clr   = wr && addr == 5'h14 && wdata[4];
            if (fresh) m_pend = 1;
            else if (clr) m_pend = 0;
            if (wr && addr == 5'h18) m_en = wdata[3:0];
            m_last = m_lvl;
            hist.push_back(lines);
            if (hist.size() > 2) void'(hist.pop_front());
            m_lvl = (hist.size() == 2) ? hist[0] : 3'b000;
            if (m_age < 3) m_age++;
        end
        #1;
        check(tag_of(addr), rdata, exp_read(addr));
        check("R7 irq", {7'b0, irq}, {7'b0, m_pend & m_en[2]});
    end

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0; wdata = 0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        lines = 3'b101;
        idle(2);
        rd_chk(5'h10, 8'h00, "R1 level in reset");
        rd_chk(5'h14, 8'h00, "R1 raw in reset");
        @(negedge clk); rst = 0;
        rd_chk(5'h18, 8'h00, "R1 enable after reset");
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        idle(6);
        // R8: steady non-zero lines through reset give no interrupt
        rd_chk(5'h14, 8'h00, "R8 raw quiet");
        rd_chk(5'h10, 8'h05, "R2 levels dcd+cts");

        wr_reg(5'h18, 8'h04);
        rd_chk(5'h18, 8'h04, "R7 enable readback");

        // R3: cts falls
        @(negedge clk); lines = 3'b100;
        idle(4);
        rd_chk(5'h14, 8'h04, "R3 raw set by cts");
        rd_chk(5'h1C, 8'h04, "R7 masked set");
        check("R7 irq high", {7'b0, irq}, 8'h01);

        // R5: acknowledge with bit 4 = 0 keeps, bit 4 = 1 clears
        wr_reg(5'h14, 8'hEF);
        rd_chk(5'h14, 8'h04, "R5 no-ack write keeps");
        wr_reg(5'h14, 8'h10);
        rd_chk(5'h14, 8'h00, "R5 ack clears");

        // R4: dsr pulses up and back down before service
        @(negedge clk); lines = 3'b110;
        @(negedge clk); lines = 3'b100;
        idle(5);
        rd_chk(5'h10, 8'h04, "R4 levels unchanged");
        rd_chk(5'h14, 8'h04, "R4 raw still latched");
        wr_reg(5'h14, 8'h10);
        rd_chk(5'h14, 8'h00, "R5 ack after double toggle");

        // R6: change hits detector on the edge of the acknowledge write
        @(negedge clk); lines = 3'b000;
        @(negedge clk);
        @(negedge clk); wr = 1; addr = 5'h14; wdata = 8'h10;
        @(negedge clk); wr = 0; wdata = 0;
        rd_chk(5'h14, 8'h04, "R6 set wins over ack");

        // R7: other enables on, modem enable off
        wr_reg(5'h18, 8'h0B);
        rd_chk(5'h18, 8'h0B, "R7 other enables stored");
        rd_chk(5'h1C, 8'h00, "R7 masked gated off");
        check("R7 irq gated", {7'b0, irq}, 8'h00);
        rd_chk(5'h14, 8'h04, "R7 raw ignores enable");

        // R9: writes to read-only and unmapped offsets
        wr_reg(5'h10, 8'hFF);
        wr_reg(5'h1C, 8'hFF);
        wr_reg(5'h04, 8'hFF);
        rd_chk(5'h10, 8'h00, "R9 level untouched");
        rd_chk(5'h14, 8'h04, "R9 raw untouched");
        rd_chk(5'h18, 8'h0B, "R9 enable untouched");
        rd_chk(5'h04, 8'h00, "R9 unmapped reads zero");

        // R3: dcd alone
        wr_reg(5'h14, 8'h10);
        wr_reg(5'h18, 8'h04);
        rd_chk(5'h14, 8'h00, "R5 cleared before dcd");
        @(negedge clk); lines = 3'b100;
        idle(4);
        rd_chk(5'h10, 8'h04, "R2 dcd level");
        rd_chk(5'h14, 8'h04, "R3 raw set by dcd");
        check("R7 irq from dcd", {7'b0, irq}, 8'h01);
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule